// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the eight-bit status word of a serial non-volatile memory and decides, one request at a time, whether a status update or an array write may go ahead. The status word holds a lock bit, two region-select bits, the write-enable flag and the write-in-progress flag. The lock bit and the region bits model non-volatile cells: they keep their value across the soft power-up reset `rst_n` and start from an all-zero shipped value. The command decoder pulses `wel_set` and `wel_clr`, raises `sr_wr_req` with a data byte, or raises `arr_wr_req` with the byte address it wants to program. The block answers with `sr_grant` or `arr_grant` in the same cycle. A granted request starts an external write engine, whose `eng_busy` flag tells the block when the program cycle ends.

A small state machine follows each granted write. From IDLE, a status grant moves to SR_ARM and an array grant moves to AR_ARM. Each ARM state waits for `eng_busy` to rise and then enters SR_PROG or AR_PROG. Each PROG state returns to IDLE when `eng_busy` falls. On that return from SR_PROG, the captured status data is committed into the non-volatile bits. Both PROG-to-IDLE returns clear the write-enable flag. The write-protect pin `wp_n` is synchronised. Its synchronised value is evaluated in the cycle in which a request would be granted.

Top module: `sr_guard`

## Requirements
- R1: `status` reads {lock bit at bit 7, zeros in bits 6..4, region bits at 3..2, write-enable at bit 1, write-in-progress at bit 0}. Bits 6..4, 1 and 0 of `sr_wr_data` are never stored.
- R2: After `rst_n` is released, the write-enable flag is 0 and the lock and region bits keep their earlier values. The shipped value of the whole word is 0x00.
- R3: `wel_set` sets the write-enable flag at the next clock, and `wel_clr` clears it. When both are high, clear wins.
- R4: The write-enable flag is cleared when a granted status write or array write completes, meaning that `eng_busy` falls in a PROG state.
- R5: `sr_grant` is high only when `sr_wr_req` is high, the state is IDLE, the write-enable flag is 1, and the hardware lock is not active.
- R6: The hardware lock is active when the lock bit is 1 and the synchronised `wp_n` is 0. It does not matter which of the two became true first. The lock blocks status writes even with write-enable set. Raising `wp_n` releases it, and the region bits stay unchanged.
- R7: Region code 00 protects nothing. Code 01 protects the top quarter (0x1800..0x1FFF for 13 address bits). Code 10 protects the top half (0x1000..0x1FFF). Code 11 protects every address.
- R8: `arr_grant` is high only when `arr_wr_req` is high, `sr_wr_req` is low, the state is IDLE, the write-enable flag is 1, and `arr_addr` lies outside the protected region.
- R9: From a grant until completion, write-in-progress reads 1. During a status write, the lock and region bits read their previous values. Requests arriving during this time get no grant.
- R10: `wp_n` passes through SYNC_STAGES flops before it is evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Soft power-up reset, active low; does not touch the non-volatile bits |
| wp_n | input | 1 | Write-protect pin, low = protect |
| wel_set | input | 1 | Pulse that sets the write-enable flag |
| wel_clr | input | 1 | Pulse that clears the write-enable flag |
| sr_wr_req | input | 1 | Status write request |
| sr_wr_data | input | 8 | Status data byte |
| arr_wr_req | input | 1 | Array write request |
| arr_addr | input | AW | Byte address of the array write |
| eng_busy | input | 1 | Write engine busy flag |
| status | output | 8 | Readable status byte |
| sr_grant | output | 1 | Status write accepted |
| arr_grant | output | 1 | Array write accepted |

## Verification
The hardest situation to reach from the ports is the hardware lock entered in each of the two orders. In the first order, the lock bit is committed while the pin is high and the pin is lowered afterwards. In the second order, the pin is lowered first and a status write that is still permitted then sets the lock bit. A third status write then tests the lock, after the pin has been allowed to pass the synchroniser. The stimulus walks through both orders, with a bench-side engine model that raises busy after each grant. It also reads the status mid-write to catch stale region bits, and it issues a second request while the first is still in flight.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SR_ARM,
        ST_SR_PROG,
        ST_AR_ARM,
        ST_AR_PROG
    } wr_state_e;

    localparam int STS_W = 8;
    localparam int BIT_LOCK = 7;
    localparam int BIT_RG_HI = 3;
    localparam int BIT_RG_LO = 2;
endpackage

// File: rtl/sr_wp_sync.sv
module sr_wp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= pin_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], pin_in};
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/sr_region.sv
module sr_region #(
    parameter int AW = 13
) (
    input  logic [1:0]    rg_code,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    always_comb begin
        unique case (rg_code)
            2'b00:   hit = 1'b0;
            2'b01:   hit = &addr[AW-1:AW-2];
            2'b10:   hit = addr[AW-1];
            default: hit = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int AW          = 13,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wp_n,
    input  logic             wel_set,
    input  logic             wel_clr,
    input  logic             sr_wr_req,
    input  logic [STS_W-1:0] sr_wr_data,
    input  logic             arr_wr_req,
    input  logic [AW-1:0]    arr_addr,
    input  logic             eng_busy,
    output logic [STS_W-1:0] status,
    output logic             sr_grant,
    output logic             arr_grant
);
    wr_state_e state_q, state_d;

    logic       wp_s;
    logic       hit;
    logic       wel_q;
    logic       nv_lock = 1'b0;
    logic [1:0] nv_rg   = 2'b00;
    logic       pend_lock;
    logic [1:0] pend_rg;
    logic       hw_lock;
    logic       idle;
    logic       done;
    logic       commit_sr;

    sr_wp_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_in  (wp_n),
        .pin_sync(wp_s)
    );

    sr_region #(.AW(AW)) u_region (
        .rg_code(nv_rg),
        .addr   (arr_addr),
        .hit    (hit)
    );

    assign hw_lock   = nv_lock && !wp_s;
    assign idle      = (state_q == ST_IDLE);
    assign done      = ((state_q == ST_SR_PROG) || (state_q == ST_AR_PROG)) && !eng_busy;
    assign commit_sr = (state_q == ST_SR_PROG) && !eng_busy;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (sr_grant)       state_d = ST_SR_ARM;
                else if (arr_grant) state_d = ST_AR_ARM;
            end
            ST_SR_ARM:  if (eng_busy)  state_d = ST_SR_PROG;
            ST_SR_PROG: if (!eng_busy) state_d = ST_IDLE;
            ST_AR_ARM:  if (eng_busy)  state_d = ST_AR_PROG;
            ST_AR_PROG: if (!eng_busy) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // volatile write-enable flag and captured status data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q     <= 1'b0;
            pend_lock <= 1'b0;
            pend_rg   <= 2'b00;
        end else begin
            if (wel_clr || done) wel_q <= 1'b0;
            else if (wel_set)    wel_q <= 1'b1;
            if (sr_grant) begin
                pend_lock <= sr_wr_data[BIT_LOCK];
                pend_rg   <= sr_wr_data[BIT_RG_HI:BIT_RG_LO];
            end
        end
    end

    // non-volatile cells: untouched by the soft reset
    always_ff @(posedge clk) begin
        if (commit_sr) begin
            nv_lock <= pend_lock;
            nv_rg   <= pend_rg;
        end
    end

    // outputs
    always_comb begin
        status    = {nv_lock, 3'b000, nv_rg, wel_q, !idle};
        sr_grant  = sr_wr_req && idle && wel_q && !hw_lock;
        arr_grant = arr_wr_req && !sr_wr_req && idle && wel_q && !hit;
    end

    AST_GRANT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_grant && arr_grant));                                            // R8
    AST_SR_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant |-> status[1]);                                              // R5
    AST_LOCK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_LOCK] && !wp_s) |-> !sr_grant);                           // R6
    AST_WEL_DONE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !status[1]);                                                 // R4
    AST_NV_HELD_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SR_ARM) |=> $stable(status[BIT_RG_HI:BIT_RG_LO]));     // R9
    AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |-> !(sr_grant || arr_grant));                              // R9
    AST_FULL_REGION: assert property (@(posedge clk) disable iff (!rst_n)
        (status[BIT_RG_HI:BIT_RG_LO] == 2'b11 && !sr_wr_req) |-> !arr_grant); // R7
endmodule

// File: tb/test_sr_guard.sv
module test_sr_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 13;
    localparam int ENG_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wp_n = 1'b1;
    logic wel_set = 1'b0, wel_clr = 1'b0;
    logic sr_wr_req = 1'b0, arr_wr_req = 1'b0;
    logic [7:0] sr_wr_data = '0;
    logic [AW-1:0] arr_addr = '0;
    logic eng_busy;
    logic [7:0] status;
    logic sr_grant, arr_grant;
    int eng_cnt = 0;
    int n_cmp = 0, n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        string      tag;
        logic [7:0] sts;
        logic       srg;
        logic       arg;
    } exp_t;
    exp_t exp_q[$];
    event ev_sample;

    always #(CLK_PERIOD/2) clk = ~clk;

    sr_guard #(.AW(AW), .SYNC_STAGES(2)) i_sr_guard (
        .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .wel_set(wel_set), .wel_clr(wel_clr),
        .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data), .arr_wr_req(arr_wr_req),
        .arr_addr(arr_addr), .eng_busy(eng_busy), .status(status),
        .sr_grant(sr_grant), .arr_grant(arr_grant)
    );

    // write engine model: busy for ENG_CYC cycles after any grant
    always @(posedge clk) begin
        if (!rst_n)                      eng_cnt <= 0;
        else if (sr_grant || arr_grant)  eng_cnt <= ENG_CYC;
        else if (eng_cnt != 0)           eng_cnt <= eng_cnt - 1;
    end
    assign eng_busy = (eng_cnt != 0);

    // monitor
    initial begin
        forever begin
            @(ev_sample);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_cmp++;
                if (status !== e.sts || sr_grant !== e.srg || arr_grant !== e.arg) begin
                    n_bad++;
                    $display("FAIL %s: status=%h srg=%b arg=%b expected status=%h srg=%b arg=%b",
                             e.tag, status, sr_grant, arr_grant, e.sts, e.srg, e.arg);
                end
            end
        end
    end

    task automatic cyc(input logic s, input logic c, input logic sq, input logic [7:0] d,
                       input logic aq, input logic [AW-1:0] a,
                       input logic [7:0] xs, input logic xsg, input logic xag, input string tag);
        exp_t e;
        @(negedge clk);
        wel_set = s; wel_clr = c; sr_wr_req = sq; sr_wr_data = d;
        arr_wr_req = aq; arr_addr = a;
        #2;
        e.tag = tag; e.sts = xs; e.srg = xsg; e.arg = xag;
        exp_q.push_back(e);
        ->ev_sample;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wel_set = 0; wel_clr = 0; sr_wr_req = 0; arr_wr_req = 0;
        end
    endtask

    task automatic chk(input logic [7:0] xs, input string tag);
        cyc(0, 0, 0, 8'h00, 0, '0, xs, 0, 0, tag);
    endtask

    task automatic soft_reset();
        @(negedge clk); rst_n = 0;
        idle(2);
        @(negedge clk); rst_n = 1;
    endtask

    initial begin
        soft_reset();
        idle(3);
        chk(8'h00, "R2 shipped value after reset");
        cyc(0, 0, 1, 8'h8C, 0, '0, 8'h00, 0, 0, "R5 status write refused without WEL");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h00, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h74, 0, '0, 8'h02, 1, 0, "R5 status write granted");
        chk(8'h03, "R9 old region bits while writing");
        idle(8);
        chk(8'h04, "R1 R4 region 01 stored, unused bits dropped, WEL cleared");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h04, 0, 0, "R3 set pulse");
        cyc(0, 0, 0, 8'h00, 1, 13'h1800, 8'h06, 0, 0, "R7 quarter bottom edge protected");
        cyc(0, 0, 0, 8'h00, 1, 13'h17FF, 8'h06, 0, 1, "R8 below quarter granted");
        idle(8);
        chk(8'h04, "R4 WEL cleared after array write");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h04, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h88, 0, '0, 8'h06, 1, 0, "R5 write lock+half");
        idle(8);
        chk(8'h88, "R1 lock bit stored");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h88, 0, 0, "R3 set pulse");
        cyc(0, 0, 0, 8'h00, 1, 13'h1000, 8'h8A, 0, 0, "R7 half boundary protected");
        cyc(0, 0, 0, 8'h00, 1, 13'h0FFF, 8'h8A, 0, 1, "R8 below half granted");
        idle(8);
        chk(8'h88, "R4 WEL cleared");
        // lock bit first, pin lowered second
        wp_n = 1'b0;
        idle(4);
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h88, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h00, 0, '0, 8'h8A, 0, 0, "R6 R10 locked after sync, WEL set");
        chk(8'h8A, "R6 no write started, WEL kept");
        cyc(0, 1, 0, 8'h00, 0, '0, 8'h8A, 0, 0, "R3 clear pulse");
        chk(8'h88, "R3 WEL cleared");
        wp_n = 1'b1;
        idle(4);
        chk(8'h88, "R6 release keeps region bits");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h88, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h0F, 0, '0, 8'h8A, 1, 0, "R6 write allowed after release");
        idle(8);
        chk(8'h0C, "R1 low data bits not stored");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h0C, 0, 0, "R3 set pulse");
        cyc(0, 0, 0, 8'h00, 1, 13'h0000, 8'h0E, 0, 0, "R7 whole array protected low");
        cyc(0, 0, 0, 8'h00, 1, 13'h1FFF, 8'h0E, 0, 0, "R7 whole array protected high");
        cyc(0, 1, 0, 8'h00, 0, '0, 8'h0E, 0, 0, "R3 clear pulse");
        // pin lowered first, lock bit set second
        wp_n = 1'b0;
        idle(4);
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h0C, 0, 0, "R3 WEL cleared earlier");
        cyc(0, 0, 1, 8'h8C, 0, '0, 8'h0E, 1, 0, "R6 pin low but lock bit 0");
        idle(8);
        chk(8'h8C, "R6 lock bit stored");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h8C, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h00, 0, '0, 8'h8E, 0, 0, "R6 pin-first order locks");
        soft_reset();
        idle(1);
        chk(8'h8C, "R2 soft reset keeps NV bits, clears WEL");
        wp_n = 1'b1;
        idle(4);
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h8C, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h00, 0, '0, 8'h8E, 1, 0, "R5 unlocked write");
        cyc(0, 0, 1, 8'h00, 0, '0, 8'h8F, 0, 0, "R9 second request refused");
        idle(8);
        chk(8'h00, "R9 commit after completion");
        cyc(1, 1, 0, 8'h00, 0, '0, 8'h00, 0, 0, "R3 set and clear together");
        chk(8'h00, "R3 clear wins");
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h00, 0, 0, "R3 set pulse");
        cyc(0, 0, 1, 8'h00, 1, 13'h0100, 8'h02, 1, 0, "R8 status request takes precedence");
        idle(8);
        cyc(1, 0, 0, 8'h00, 0, '0, 8'h00, 0, 0, "R3 set pulse");
        cyc(0, 0, 0, 8'h00, 1, 13'h1FFF, 8'h02, 0, 1, "R7 code 00 protects nothing");
        chk(8'h03, "R9 WIP during array write");
        idle(8);
        chk(8'h00, "R4 array write completion");
        idle(2);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not end, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule